// File: doc/BRIEF.md
# NAND Flash Host Register Front End

This block connects a simple processor register bus to a raw 8-bit NAND flash device. A control register drives the flash latch and enable pins and shows the live ready/busy pin. A data port passes bytes to and from the flash. Every byte that crosses the data port, in either direction, is folded into a hardware Hamming ECC accumulator.

Software clears the accumulator and moves one 256-byte page through the data port. It then reads the line parity, the column parity and the byte count back from the ECC registers and compares them with the parity stored in the spare area. A 32-bit read of the data port fetches two flash bytes in one bus access.

Bus accesses are single-cycle request pulses. Each access ends with a one-cycle `busAck`, and `busRdata` is valid during that cycle. Only bits 7:0 of write data are significant.

Top module: `nand_host_regs`

## Requirements
- R1: After reset, every stored control bit is 0. The pins flashCle, flashAle, flashCeN and flashWp are low, flashRd, flashWr and busAck are low, and the parity and counter registers read 0.
- R2: A write to offset 0x18 stores bits 7:0, except that bit 5 is always stored as 0. flashCle follows bit 1, flashAle follows bit 2 and flashWp follows bit 3. A read of 0x18 returns the stored bits with bit 5 set to the level of flashReady.
- R3: flashCeN is the OR of control bit 0 and control bit 4.
- R4: A write to offset 0x14 gives exactly one flashWr cycle, in the ack cycle, with flashDout equal to the written byte. That byte is folded into the ECC, and busAck follows the request by one cycle.
- R5: A narrow read of 0x14 (busWide=0) gives one flashRd cycle. The byte present on flashDin in that cycle is returned in bits 7:0, the other bits are 0, and ack comes two cycles after the request.
- R6: A wide read of 0x14 (busWide=1) gives two consecutive flashRd cycles. The first byte is returned in bits 7:0 and the second in bits 23:16, all other bits are 0, both bytes are folded into the ECC, and ack comes three cycles after the request.
- R7: The column parity reads at 0x08, bits 5:0. Each folded byte XORs into it as follows: bit 0 takes data bits 0,2,4,6; bit 1 takes bits 1,3,5,7; bit 2 takes bits 0,1,4,5; bit 3 takes bits 2,3,6,7; bit 4 takes bits 0–3; bit 5 takes bits 4–7.
- R8: The line parity L[15:0] works as follows. For a folded byte with XOR p and index n (the counter value before the fold), each address bit k XORs p into L[2k+1] if n[k] is 1, otherwise into L[2k]. Offset 0x00 returns bit 2j = L[4+j] and bit 2j+1 = L[12+j]. Offset 0x04 returns bit 2j = L[j] and bit 2j+1 = L[8+j], for j = 0..3.
- R9: Offset 0x0C returns, in bits 7:0, the number of bytes folded since the last clear, modulo 256.
- R10: Any write to offset 0x10 zeroes the line parity, the column parity and the counter, whatever the written value.
- R11: Reads of unmapped offsets, and of 0x10, return 0 with ack one cycle after the request. Writes to 0x00, 0x04, 0x08, 0x0C or unmapped offsets change no register and no pin.
- R12: Every request produces exactly one ack cycle. Accesses other than data reads ack one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | One-cycle access request, issued only while idle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busWide | input | 1 | 32-bit access (matters only for data reads) |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 8 | Write data |
| busAck | output | 1 | One-cycle access completion |
| busRdata | output | 32 | Read data, valid while busAck is high |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashCeN | output | 1 | Active-low chip enable |
| flashWp | output | 1 | Write-protect pin |
| flashReady | input | 1 | Flash ready/busy level |
| flashRd | output | 1 | Flash byte read strobe |
| flashWr | output | 1 | Flash byte write strobe |
| flashDout | output | 8 | Byte to the flash |
| flashDin | input | 8 | Byte from the flash |

## Verification
The assertions assume that busReq is a one-cycle pulse raised only while no access is in progress, because the request-to-response property reads the state that follows a request. The bench meets this by issuing a request only after the previous ack and dropping busReq after one clock. The assertions also assume that flashDin and flashReady do not change at the clock edge where they are sampled. The bench's flash model changes flashDin only on the edge that ends a read strobe, and the bench holds flashReady steady around each control read.

// File: rtl/nand_host_pkg.sv
package nand_host_pkg;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = 32;
  localparam int LINE_W  = 16;
  localparam int COL_W   = 6;
  localparam int HALF_LN = LINE_W / 2;

  localparam int OFS_LPLO  = 'h00;
  localparam int OFS_LPHI  = 'h04;
  localparam int OFS_COL   = 'h08;
  localparam int OFS_CNT   = 'h0C;
  localparam int OFS_CLEAR = 'h10;
  localparam int OFS_DATA  = 'h14;
  localparam int OFS_CTL   = 'h18;

  localparam int BIT_CE0   = 0;
  localparam int BIT_CLE   = 1;
  localparam int BIT_ALE   = 2;
  localparam int BIT_WP    = 3;
  localparam int BIT_CE1   = 4;
  localparam int BIT_READY = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_DONE  = 2'd3
  } accState_e;

  typedef struct packed {
    logic eccClear;
    logic digest;
    logic fromFlash;
    logic capLo;
    logic capHi;
    logic loadReg;
    logic zeroData;
  } dpStrobe_t;
endpackage

// File: rtl/nand_host_ctrl.sv
module nand_host_ctrl
  import nand_host_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic              flashReady,
  output logic              busAck,
  output logic              flashRd,
  output logic              flashWr,
  output logic              flashCle,
  output logic              flashAle,
  output logic              flashCeN,
  output logic              flashWp,
  output logic [BYTE_W-1:0] ctlView,
  output dpStrobe_t         strb
);
  accState_e state, nextState;
  logic [BYTE_W-1:0] ctlReg;
  logic wideQ;
  logic wrPulse;
  logic isData, isClear, isCtl;
  logic startAcc;

  assign isData   = (busAddr == ADDR_W'(OFS_DATA));
  assign isClear  = (busAddr == ADDR_W'(OFS_CLEAR));
  assign isCtl    = (busAddr == ADDR_W'(OFS_CTL));
  assign startAcc = (state == ST_IDLE) && busReq;

  always_comb begin
    strb      = '0;
    nextState = state;
    flashRd   = 1'b0;
    busAck    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (busReq) begin
          if (busWrite) begin
            strb.digest   = isData;
            strb.eccClear = isClear;
            nextState     = ST_DONE;
          end else if (isData) begin
            strb.zeroData = 1'b1;
            nextState     = ST_RD_LO;
          end else begin
            strb.loadReg  = 1'b1;
            nextState     = ST_DONE;
          end
        end
      end
      ST_RD_LO: begin
        flashRd        = 1'b1;
        strb.digest    = 1'b1;
        strb.fromFlash = 1'b1;
        strb.capLo     = 1'b1;
        nextState      = wideQ ? ST_RD_HI : ST_DONE;
      end
      ST_RD_HI: begin
        flashRd        = 1'b1;
        strb.digest    = 1'b1;
        strb.fromFlash = 1'b1;
        strb.capHi     = 1'b1;
        nextState      = ST_DONE;
      end
      ST_DONE: begin
        busAck    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wideQ   <= 1'b0;
      ctlReg  <= '0;
      wrPulse <= 1'b0;
    end else begin
      state   <= nextState;
      wrPulse <= startAcc && busWrite && isData;
      if (startAcc) wideQ <= busWide;
      if (startAcc && busWrite && isCtl) begin
        ctlReg            <= busWdata;
        ctlReg[BIT_READY] <= 1'b0;
      end
    end
  end

  assign flashWr  = wrPulse;
  assign flashCle = ctlReg[BIT_CLE];
  assign flashAle = ctlReg[BIT_ALE];
  assign flashWp  = ctlReg[BIT_WP];
  assign flashCeN = ctlReg[BIT_CE0] | ctlReg[BIT_CE1];

  always_comb begin
    ctlView            = ctlReg;
    ctlView[BIT_READY] = flashReady;
  end
endmodule

// File: rtl/nand_host_dp.sv
module nand_host_dp
  import nand_host_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] flashDin,
  input  logic [BYTE_W-1:0] ctlView,
  output logic [DATA_W-1:0] busRdata,
  output logic [BYTE_W-1:0] flashDout
);
  logic [LINE_W-1:0] lineParity, lineNext;
  logic [COL_W-1:0]  colParity, colNext;
  logic [BYTE_W-1:0] byteCount;
  logic [BYTE_W-1:0] inByte;
  logic [BYTE_W-1:0] doutQ;
  logic [DATA_W-1:0] readData, regVal;
  logic [BYTE_W-1:0] lpLoView, lpHiView;
  logic bytePar;

  assign inByte  = strb.fromFlash ? flashDin : busWdata;
  assign bytePar = ^inByte;

  always_comb begin
    lineNext = lineParity;
    for (int k = 0; k < BYTE_W; k++) begin
      if (byteCount[k]) lineNext[2*k+1] = lineParity[2*k+1] ^ bytePar;
      else              lineNext[2*k]   = lineParity[2*k]   ^ bytePar;
    end
  end

  always_comb begin
    colNext[0] = colParity[0] ^ inByte[0] ^ inByte[2] ^ inByte[4] ^ inByte[6];
    colNext[1] = colParity[1] ^ inByte[1] ^ inByte[3] ^ inByte[5] ^ inByte[7];
    colNext[2] = colParity[2] ^ inByte[0] ^ inByte[1] ^ inByte[4] ^ inByte[5];
    colNext[3] = colParity[3] ^ inByte[2] ^ inByte[3] ^ inByte[6] ^ inByte[7];
    colNext[4] = colParity[4] ^ (^inByte[3:0]);
    colNext[5] = colParity[5] ^ (^inByte[7:4]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineParity <= '0;
      colParity  <= '0;
      byteCount  <= '0;
      doutQ      <= '0;
    end else if (strb.eccClear) begin
      lineParity <= '0;
      colParity  <= '0;
      byteCount  <= '0;
    end else if (strb.digest) begin
      lineParity <= lineNext;
      colParity  <= colNext;
      byteCount  <= byteCount + 1'b1;
      if (!strb.fromFlash) doutQ <= inByte;
    end
  end

  for (genvar j = 0; j < 4; j++) begin : g_ilv
    assign lpLoView[2*j]   = lineParity[4+j];
    assign lpLoView[2*j+1] = lineParity[HALF_LN+4+j];
    assign lpHiView[2*j]   = lineParity[j];
    assign lpHiView[2*j+1] = lineParity[HALF_LN+j];
  end

  always_comb begin
    regVal = '0;
    case (busAddr)
      ADDR_W'(OFS_LPLO): regVal[BYTE_W-1:0] = lpLoView;
      ADDR_W'(OFS_LPHI): regVal[BYTE_W-1:0] = lpHiView;
      ADDR_W'(OFS_COL):  regVal[COL_W-1:0]  = colParity;
      ADDR_W'(OFS_CNT):  regVal[BYTE_W-1:0] = byteCount;
      ADDR_W'(OFS_CTL):  regVal[BYTE_W-1:0] = ctlView;
      default:           regVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readData <= '0;
    end else if (strb.zeroData) begin
      readData <= '0;
    end else if (strb.loadReg) begin
      readData <= regVal;
    end else begin
      if (strb.capLo) readData[BYTE_W-1:0] <= flashDin;
      if (strb.capHi) readData[2*BYTE_W+BYTE_W-1:2*BYTE_W] <= flashDin;
    end
  end

  assign busRdata  = readData;
  assign flashDout = doutQ;
endmodule

// File: rtl/nand_host_regs.sv
module nand_host_regs
  import nand_host_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic              busAck,
  output logic [31:0]       busRdata,
  output logic              flashCle,
  output logic              flashAle,
  output logic              flashCeN,
  output logic              flashWp,
  input  logic              flashReady,
  output logic              flashRd,
  output logic              flashWr,
  output logic [7:0]        flashDout,
  input  logic [7:0]        flashDin
);
  dpStrobe_t strb;
  logic [BYTE_W-1:0] ctlView;

  nand_host_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busWide(busWide), .busAddr(busAddr), .busWdata(busWdata),
    .flashReady(flashReady), .busAck(busAck), .flashRd(flashRd),
    .flashWr(flashWr), .flashCle(flashCle), .flashAle(flashAle),
    .flashCeN(flashCeN), .flashWp(flashWp), .ctlView(ctlView), .strb(strb)
  );

  nand_host_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .flashDin(flashDin), .ctlView(ctlView),
    .busRdata(busRdata), .flashDout(flashDout)
  );
endmodule

// File: rtl/nand_host_regs_chk.sv
module nand_host_regs_chk (
  input logic clk,
  input logic rstN,
  input logic busReq,
  input logic busAck,
  input logic flashRd,
  input logic flashWr
);
  // R12
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);

  // R12
  req_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> (busAck || flashRd));

  // R4
  wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashWr |-> busAck);

  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flashRd && flashWr));

  // R6
  rd_before_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashRd |-> !busAck);

  // R6
  rd_then_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashRd) |-> busAck);
endmodule

bind nand_host_regs nand_host_regs_chk u_chk (.*);

// File: tb/nand_host_regs_tb.sv
module nand_host_regs_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReq = 1'b0, busWrite = 1'b0, busWide = 1'b0;
  logic [5:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic busAck;
  logic [31:0] busRdata;
  logic flashCle, flashAle, flashCeN, flashWp;
  logic flashReady = 1'b0;
  logic flashRd, flashWr;
  logic [7:0] flashDout, flashDin;

  always #10 clk = ~clk;

  nand_host_regs u_dut (.*);

  // flash model
  logic [7:0] page [256];
  logic [7:0] rdPtr = '0;
  int rdCount = 0, wrCount = 0;
  logic [7:0] lastWr = '0;
  assign flashDin = page[rdPtr];
  always @(posedge clk) begin
    if (flashRd) begin rdPtr <= rdPtr + 8'd1; rdCount <= rdCount + 1; end
    if (flashWr) begin wrCount <= wrCount + 1; lastWr <= flashDout; end
  end

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic wide, input logic [5:0] addr,
                        input logic [7:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busWide = wide; busAddr = addr; busWdata = wd;
    @(negedge clk);
    busReq = 1'b0;
    cyc = 1;
    while (!busAck) begin @(negedge clk); cyc++; end
    rd = busRdata;
  endtask

  // independent ECC model
  logic [15:0] mLine;
  logic [5:0]  mCol;
  logic [7:0]  mCnt;
  task automatic modelClear(); mLine = '0; mCol = '0; mCnt = '0; endtask
  task automatic modelFold(input logic [7:0] b);
    logic p;
    p = ^b;
    for (int k = 0; k < 8; k++) begin
      if (mCnt[k]) mLine[2*k+1] ^= p; else mLine[2*k] ^= p;
    end
    for (int i = 0; i < 8; i++) begin
      if (b[i]) begin
        for (int a = 0; a < 3; a++) begin
          logic [2:0] iv;
          iv = 3'(i);
          mCol[2*a + int'(iv[a])] ^= 1'b1;
        end
      end
    end
    mCnt = mCnt + 8'd1;
  endtask
  function automatic logic [7:0] expLo();
    logic [7:0] v;
    for (int j = 0; j < 4; j++) begin v[2*j] = mLine[4+j]; v[2*j+1] = mLine[12+j]; end
    return v;
  endfunction
  function automatic logic [7:0] expHi();
    logic [7:0] v;
    for (int j = 0; j < 4; j++) begin v[2*j] = mLine[j]; v[2*j+1] = mLine[8+j]; end
    return v;
  endfunction

  task automatic checkEcc(input string tag);
    logic [31:0] rd; int cyc;
    access(1'b0, 1'b0, 6'h00, 8'h00, rd, cyc); check({tag, " R8 lineLo"}, rd, {24'h0, expLo()});
    access(1'b0, 1'b0, 6'h04, 8'h00, rd, cyc); check({tag, " R8 lineHi"}, rd, {24'h0, expHi()});
    access(1'b0, 1'b0, 6'h08, 8'h00, rd, cyc); check({tag, " R7 column"}, rd, {26'h0, mCol});
    access(1'b0, 1'b0, 6'h0C, 8'h00, rd, cyc); check({tag, " R9 count"}, rd, {24'h0, mCnt});
  endtask

  // control vectors: {wdata, expected readback, 3'b0, ready, pins {wp,ceN,ale,cle}}
  localparam logic [23:0] CTL_VEC [9] = '{
    24'h00_00_00, 24'h01_21_14, 24'h10_10_04, 24'h02_02_01, 24'h04_24_12,
    24'h08_08_08, 24'h20_00_00, 24'h3F_3F_1F, 24'hFF_DF_0F
  };

  logic [7:0] ptrExp = '0;

  initial begin
    logic [31:0] rd;
    int cyc;
    int r0;
    for (int i = 0; i < 256; i++) page[i] = 8'($urandom);
    modelClear();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins", {28'h0, flashWp, flashCeN, flashAle, flashCle}, 32'h0);
    check("R1 strobes", {29'h0, busAck, flashRd, flashWr}, 32'h0);
    rstN = 1'b1;
    checkEcc("R1 reset");

    // R2 R3 table walk
    for (int v = 0; v < 9; v++) begin
      logic [23:0] e;
      e = CTL_VEC[v];
      flashReady = e[4];
      access(1'b1, 1'b0, 6'h18, e[23:16], rd, cyc);
      check("R2 R3 pins", {28'h0, flashWp, flashCeN, flashAle, flashCle}, {28'h0, e[3:0]});
      access(1'b0, 1'b0, 6'h18, 8'h00, rd, cyc);
      check("R2 readback", rd, {24'h0, e[15:8]});
    end
    access(1'b1, 1'b0, 6'h18, 8'h00, rd, cyc);

    // R4 data write
    r0 = wrCount;
    access(1'b1, 1'b0, 6'h14, 8'hA5, rd, cyc);
    check("R4 ack latency", cyc, 1);
    @(negedge clk);
    check("R4 one strobe", wrCount - r0, 1);
    check("R4 byte", {24'h0, lastWr}, 32'hA5);
    modelFold(8'hA5);
    access(1'b1, 1'b0, 6'h14, 8'h3C, rd, cyc);
    modelFold(8'h3C);
    checkEcc("R4 fold");

    // R10 clear with nonzero value
    access(1'b1, 1'b0, 6'h10, 8'h5A, rd, cyc);
    modelClear();
    checkEcc("R10 clear");

    // R5 narrow read
    r0 = rdCount;
    access(1'b0, 1'b0, 6'h14, 8'h00, rd, cyc);
    check("R5 latency", cyc, 2);
    check("R5 data", rd, {24'h0, page[ptrExp]});
    modelFold(page[ptrExp]); ptrExp++;
    @(negedge clk);
    check("R5 one strobe", rdCount - r0, 1);

    // R6 wide read
    r0 = rdCount;
    access(1'b0, 1'b1, 6'h14, 8'h00, rd, cyc);
    check("R6 latency", cyc, 3);
    check("R6 data", rd, {8'h0, page[8'(ptrExp + 8'd1)], 8'h0, page[ptrExp]});
    modelFold(page[ptrExp]); ptrExp++;
    modelFold(page[ptrExp]); ptrExp++;
    @(negedge clk);
    check("R6 two strobes", rdCount - r0, 2);
    checkEcc("R6 fold");

    // full page of wide reads after clear, R7 R8 R9 wrap
    access(1'b1, 1'b0, 6'h10, 8'hFF, rd, cyc);
    modelClear();
    for (int w = 0; w < 128; w++) begin
      access(1'b0, 1'b1, 6'h14, 8'h00, rd, cyc);
      if (rd !== {8'h0, page[8'(ptrExp + 8'd1)], 8'h0, page[ptrExp]})
        check("R6 page data", rd, {8'h0, page[8'(ptrExp + 8'd1)], 8'h0, page[ptrExp]});
      modelFold(page[ptrExp]); ptrExp++;
      modelFold(page[ptrExp]); ptrExp++;
    end
    checkEcc("R7 R8 page");
    for (int n = 0; n < 3; n++) begin
      access(1'b0, 1'b0, 6'h14, 8'h00, rd, cyc);
      modelFold(page[ptrExp]); ptrExp++;
    end
    checkEcc("R9 after wrap");

    // R11 unmapped and read-only
    access(1'b0, 1'b0, 6'h1C, 8'h00, rd, cyc);
    check("R11 unmapped 1C", rd, 32'h0);
    check("R11 latency", cyc, 1);
    access(1'b0, 1'b0, 6'h3C, 8'h00, rd, cyc);
    check("R11 unmapped 3C", rd, 32'h0);
    access(1'b0, 1'b0, 6'h10, 8'h00, rd, cyc);
    check("R11 clear reads 0", rd, 32'h0);
    r0 = wrCount;
    access(1'b1, 1'b0, 6'h08, 8'hFF, rd, cyc);
    access(1'b1, 1'b0, 6'h0C, 8'h77, rd, cyc);
    access(1'b1, 1'b0, 6'h00, 8'hFF, rd, cyc);
    access(1'b1, 1'b0, 6'h2C, 8'h1F, rd, cyc);
    @(negedge clk);
    check("R11 no flash write", wrCount - r0, 0);
    check("R11 pins kept", {28'h0, flashWp, flashCeN, flashAle, flashCle}, 32'h0);
    checkEcc("R11 ecc kept");

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL R12 watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule